// File: doc/BRIEF.md
# Byte-Fed Serial Transmitter with Line Format Control

This block turns bytes written over a simple register write port into an asynchronous serial stream on one output pin. Bytes are queued in a 16-entry FIFO. A serializer takes them one at a time and sends a low start bit, then 5 to 8 data bits least significant first, then an optional parity bit, then a high stop period. All timing comes from a baud tick that divides the system clock by a 16-bit divisor. Every serial bit lasts 16 ticks.

Software sets the line format through a format register at byte offset 8. Its fields are:

| Bits | Field |
|------|-------|
| [1:0] | word length |
| [2] | stop length |
| [3] | parity enable |
| [5:4] | parity mode |
| [6] | forced break |
| [7] | divisor select |

While divisor select is set, offsets 0 and 4 load the low and high divisor bytes. While it is clear, offset 0 pushes a byte into the FIFO. A status output reports when nothing is left to send.

Top module: `uart_tx_line`

## Requirements
- R1: After reset, `tx` is 1 and `tx_empty` is 1. The format register and the divisor both reset to zero.
- R2: Format bits [1:0] give the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8. Data bits above that length are not sent.
- R3: A frame has four parts in this order: one start bit at 0, the data bits least significant first, the optional parity bit, and a stop period at 1. Each start, data or parity bit lasts 16 baud ticks.
- R4: Format bit 3 set adds one parity bit after the data. Bits [5:4] choose its value: 00 makes the count of ones in data plus parity odd, 01 makes it even, 10 forces the bit to 1, 11 forces it to 0.
- R5: The stop period lasts 16 ticks when format bit 2 is 0. When bit 2 is 1 it lasts 32 ticks, or 24 ticks when the word length is 5.
- R6: While format bit 6 is 1, `tx` is 0, and it stays 0 whatever the serializer is doing.
- R7: With format bit 7 at 1, writes to offset 0 and offset 4 load the divisor low and high bytes and push nothing into the FIFO. With bit 7 at 0, a write to offset 0 pushes the byte.
- R8: The baud tick fires once every `D` clock cycles, where `D` is the divisor. A divisor of 0 acts as 1, so one bit then lasts 16 clock cycles.
- R9: The FIFO holds 16 bytes. A write to offset 0 while the FIFO is full is dropped.
- R10: `tx_empty` is 1 only when the FIFO is empty and no frame is in progress. It falls in the cycle after a byte is pushed into an idle block.
- R11: If a byte is waiting when a stop period ends, the next start bit begins on that same tick. Back-to-back frames therefore repeat every D × ((1 + bits + parity) × 16 + stop ticks) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte offset of the write: 0, 4 or 8 |
| wr_data | input | 8 | Write data byte |
| tx | output | 1 | Serial output line, idle high |
| tx_empty | output | 1 | High when the FIFO and the serializer are both empty |

## Verification
The hardest state to reach from the ports is a full FIFO receiving a further write. The serializer drains one entry as soon as the first byte arrives, so the FIFO only fills if 17 more bytes arrive before the first frame ends. The bench sets a divisor of 4 and writes 20 bytes on consecutive cycles. It then expects exactly 17 frames, carrying the first 17 values, and after them a quiet line.

The stop lengths of 1.5 and 2 bits are measured as the spacing between the starts of the second and third back-to-back frames. A randomized sweep over formats and divisors uses the same measurement.

// File: rtl/uart_tx_pkg.sv
`timescale 1ns/1ps
package uart_tx_pkg;
  // Format register layout, most significant bit first.
  typedef struct packed {
    logic       dlab;   // [7] divisor select
    logic       brk;    // [6] forced break
    logic [1:0] pmode;  // [5:4] parity mode
    logic       pen;    // [3] parity enable
    logic       stop2;  // [2] long stop
    logic [1:0] wlen;   // [1:0] word length code
  } lcr_t;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} txst_t;

  localparam logic [3:0] OFF_DATA = 4'h0;
  localparam logic [3:0] OFF_DIVH = 4'h4;
  localparam logic [3:0] OFF_LCR  = 4'h8;
endpackage

// File: rtl/uart_tx_baud.sv
`timescale 1ns/1ps
module uart_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, div_eff;

  always_comb begin
    div_eff = (divisor == '0) ? DIV_W'(1) : divisor;
    tick    = (cnt_q >= div_eff - DIV_W'(1));
    cnt_d   = tick ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tx_fifo.sv
`timescale 1ns/1ps
module uart_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CW'(DEPTH));
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    wr_d    = wr_q;
    rd_d    = rd_q;
    if (push_ok) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_ok)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
    dout  = mem[rd_q];
    count = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
`timescale 1ns/1ps
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int OVS    = 16,
  localparam int SUB_W = $clog2(2 * OVS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] wlen,
  input  logic       stop2,
  input  logic       pen,
  input  logic [1:0] pmode,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_dout,
  output logic       pop,
  output logic       line,
  output logic       busy
);
  localparam logic [SUB_W-1:0] BIT_LAST  = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] HALF_LAST = SUB_W'(OVS + OVS / 2 - 1);
  localparam logic [SUB_W-1:0] TWO_LAST  = SUB_W'(2 * OVS - 1);

  txst_t            st_q, st_d;
  logic [SUB_W-1:0] sub_q, sub_d, stop_last;
  logic [2:0]       bit_q, bit_d, last_bit;
  logic [7:0]       sh_q, sh_d, masked;
  logic             par_q, par_d, par_new, bit_end;

  always_comb begin
    last_bit  = 3'd4 + {1'b0, wlen};
    masked    = fifo_dout & (8'hFF >> (2'd3 - wlen));
    case (pmode)
      2'b00:   par_new = ~(^masked);
      2'b01:   par_new = ^masked;
      2'b10:   par_new = 1'b1;
      default: par_new = 1'b0;
    endcase
    if (!stop2)             stop_last = BIT_LAST;
    else if (wlen == 2'b00) stop_last = HALF_LAST;
    else                    stop_last = TWO_LAST;
    bit_end = tick && (sub_q == BIT_LAST);
  end

  always_comb begin
    st_d  = st_q;
    sub_d = tick ? sub_q + 1'b1 : sub_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    par_d = par_q;
    pop   = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        sub_d = '0;
        if (tick && !fifo_empty) begin
          pop   = 1'b1;
          sh_d  = fifo_dout;
          par_d = par_new;
          st_d  = S_START;
        end
      end
      S_START: if (bit_end) begin
        st_d  = S_DATA;
        sub_d = '0;
        bit_d = '0;
      end
      S_DATA: if (bit_end) begin
        sub_d = '0;
        if (bit_q == last_bit) st_d = pen ? S_PAR : S_STOP;
        else begin
          bit_d = bit_q + 1'b1;
          sh_d  = sh_q >> 1;
        end
      end
      S_PAR: if (bit_end) begin
        st_d  = S_STOP;
        sub_d = '0;
      end
      S_STOP: if (tick && sub_q == stop_last) begin
        sub_d = '0;
        if (!fifo_empty) begin
          pop   = 1'b1;
          sh_d  = fifo_dout;
          par_d = par_new;
          st_d  = S_START;
        end else begin
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    case (st_q)
      S_START: line = 1'b0;
      S_DATA:  line = sh_q[0];
      S_PAR:   line = par_q;
      default: line = 1'b1;
    endcase
    busy = (st_q != S_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      sub_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      sub_q <= sub_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      par_q <= par_d;
    end
  end
endmodule

// File: rtl/uart_tx_line.sv
`timescale 1ns/1ps
module uart_tx_line
  import uart_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int OVS        = 16,
  localparam int DIV_W     = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       tx,
  output logic       tx_empty
);
  lcr_t          lcr_q;
  logic [7:0]    div_lo_q, div_hi_q;
  logic          lcr_we, divl_we, divh_we, push_req;
  logic          tick, pop, fifo_empty, fifo_full, busy, line;
  logic [7:0]    fifo_dout;
  logic [CW-1:0] fifo_cnt;

  always_comb begin
    lcr_we   = wr_en && (wr_addr == OFF_LCR);
    divl_we  = wr_en && (wr_addr == OFF_DATA) && lcr_q.dlab;
    divh_we  = wr_en && (wr_addr == OFF_DIVH) && lcr_q.dlab;
    push_req = wr_en && (wr_addr == OFF_DATA) && !lcr_q.dlab;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcr_q    <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
    end else begin
      if (lcr_we)  lcr_q    <= lcr_t'(wr_data);
      if (divl_we) div_lo_q <= wr_data;
      if (divh_we) div_hi_q <= wr_data;
    end
  end

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor({div_hi_q, div_lo_q}), .tick(tick)
  );

  uart_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push_req), .din(wr_data), .pop(pop),
    .dout(fifo_dout), .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
  );

  uart_tx_shift #(.OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wlen(lcr_q.wlen), .stop2(lcr_q.stop2),
    .pen(lcr_q.pen), .pmode(lcr_q.pmode), .fifo_empty(fifo_empty),
    .fifo_dout(fifo_dout), .pop(pop), .line(line), .busy(busy)
  );

  always_comb begin
    tx       = line & ~lcr_q.brk;
    tx_empty = fifo_empty & ~busy;
  end
endmodule

// File: rtl/uart_tx_line_chk.sv
`timescale 1ns/1ps
module uart_tx_line_chk
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [7:0]    wr_data,
  input logic          tx,
  input logic          tx_empty,
  input logic          brk,
  input logic          dlab,
  input logic [CW-1:0] fifo_cnt,
  input logic          fifo_full,
  input logic          pop
);
  assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_LCR && wr_data[6]) |=> !tx);

  assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> tx);

  assert_push_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_DATA && !dlab && tx_empty) |=> !tx_empty);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  assert_drop_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_DATA && !dlab && fifo_full && !pop) |=> $stable(fifo_cnt));

  assert_div_write_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFF_DATA && dlab && !pop) |=> $stable(fifo_cnt));
endmodule

bind uart_tx_line uart_tx_line_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tx(tx), .tx_empty(tx_empty), .brk(lcr_q.brk), .dlab(lcr_q.dlab),
  .fifo_cnt(fifo_cnt), .fifo_full(fifo_full), .pop(pop)
);

// File: tb/sim_uart_tx_line.sv
`timescale 1ns/1ps
module sim_uart_tx_line;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic       tx, tx_empty;
  int cyc = 0;
  int nchk = 0;
  int nfail = 0;

  uart_tx_line u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tx(tx), .tx_empty(tx_empty)
  );

  always #2.5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int n_bits(input logic [7:0] l);
    return 5 + int'(l[1:0]);
  endfunction
  function automatic int stop_ticks(input logic [7:0] l);
    if (!l[2]) return 16;
    return (l[1:0] == 2'b00) ? 24 : 32;
  endfunction
  function automatic int frame_ticks(input logic [7:0] l);
    return (1 + n_bits(l) + int'(l[3])) * 16 + stop_ticks(l);
  endfunction
  function automatic logic [7:0] mask_of(input logic [7:0] l);
    return 8'hFF >> (8 - n_bits(l));
  endfunction
  function automatic logic par_of(input logic [7:0] l, input logic [7:0] d);
    logic x;
    x = ^(d & mask_of(l));
    case (l[5:4])
      2'b00:   return ~x;
      2'b01:   return x;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (!tx_empty) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cfg(input logic [7:0] l, input logic [15:0] dv);
    wait_idle();
    wr(4'h8, 8'h80);
    wr(4'h0, dv[7:0]);
    wr(4'h4, dv[15:8]);
    wr(4'h8, l);
  endtask

  // Receive one frame, sampling each bit at its middle.
  task automatic rx_frame(input logic [7:0] l, input int dv, input logic [7:0] d,
                          input string tag, output int st);
    logic [7:0] got;
    logic s0, sp, ss;
    int n, p;
    n = n_bits(l); p = int'(l[3]); got = 8'h00; sp = 1'b0;
    while (tx !== 1'b0) @(negedge clk);
    st = cyc;
    wait_cyc(st + 8 * dv); s0 = tx;
    for (int i = 0; i < n; i++) begin
      wait_cyc(st + 8 * dv + 16 * dv * (i + 1));
      got[i] = tx;
    end
    if (p != 0) begin
      wait_cyc(st + 8 * dv + 16 * dv * (n + 1));
      sp = tx;
    end
    wait_cyc(st + 8 * dv + 16 * dv * (n + 1 + p));
    ss = tx;
    chk(got == (d & mask_of(l)), tag, int'(got), int'(d & mask_of(l)));
    if (p != 0) chk(sp == par_of(l, d), "R4 parity", int'(sp), int'(par_of(l, d)));
    chk(s0 == 1'b0 && ss == 1'b1, "R3 start/stop", int'({s0, ss}), 1);
  endtask

  // Three back-to-back bytes; the spacing of frames 2 and 3 is checked exactly.
  task automatic send3(input logic [7:0] l, input int dv, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] c, input string gtag);
    int s1, s2, s3;
    wr(4'h0, a); wr(4'h0, b); wr(4'h0, c);
    rx_frame(l, dv, a, "R3 data", s1);
    rx_frame(l, dv, b, "R3 data", s2);
    rx_frame(l, dv, c, "R3 data", s3);
    chk((s3 - s2) == dv * frame_ticks(l), gtag, s3 - s2, dv * frame_ticks(l));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int st, lows;
    logic [7:0] l;
    int dv;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(tx == 1'b1 && tx_empty == 1'b1, "R1 in reset", int'({tx, tx_empty}), 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1 && tx_empty == 1'b1, "R1 after reset", int'({tx, tx_empty}), 3);

    // R7: writes under divisor select do not push.
    wr(4'h8, 8'h80); wr(4'h0, 8'h02); wr(4'h4, 8'h00);
    repeat (4) @(negedge clk);
    chk(tx_empty == 1'b1 && tx == 1'b1, "R7 divisor write no push", int'({tx, tx_empty}), 3);
    wr(4'h8, 8'h03);

    // R10: push into idle block clears empty next cycle.
    wr(4'h0, 8'hA5);
    chk(tx_empty == 1'b0, "R10 empty falls", int'(tx_empty), 0);
    rx_frame(8'h03, 2, 8'hA5, "R3 lsb first", st);

    // R5 and R11 stop lengths.
    cfg(8'h03, 16'd2); send3(8'h03, 2, 8'h3C, 8'hC3, 8'h81, "R11 back-to-back 1 stop");
    cfg(8'h07, 16'd2); send3(8'h07, 2, 8'h55, 8'hAA, 8'h0F, "R5 two stop");
    cfg(8'h04, 16'd2); send3(8'h04, 2, 8'hF3, 8'h2A, 8'h11, "R5 one and half stop");

    // R2 word lengths with bits above length that would break the stop sample.
    cfg(8'h00, 16'd1); wr(4'h0, 8'hDF); rx_frame(8'h00, 1, 8'hDF, "R2 five bits", st);
    cfg(8'h01, 16'd1); wr(4'h0, 8'hAA); rx_frame(8'h01, 1, 8'hAA, "R2 six bits", st);
    cfg(8'h02, 16'd1); wr(4'h0, 8'h7F); rx_frame(8'h02, 1, 8'h7F, "R2 seven bits", st);

    // R4 parity modes.
    for (int m = 0; m < 4; m++) begin
      l = 8'h0B | 8'(m << 4);
      cfg(l, 16'd1);
      wr(4'h0, 8'h5A); rx_frame(l, 1, 8'h5A, "R4 data", st);
      wr(4'h0, 8'h01); rx_frame(l, 1, 8'h01, "R4 data", st);
    end

    // R8 divisor of zero acts as one.
    cfg(8'h03, 16'd0); send3(8'h03, 1, 8'h12, 8'h34, 8'h56, "R8 zero divisor");

    // R6 break.
    wait_idle();
    wr(4'h8, 8'h43);
    chk(tx == 1'b0, "R6 break low", int'(tx), 0);
    repeat (20) @(negedge clk);
    chk(tx == 1'b0, "R6 break held", int'(tx), 0);
    wr(4'h8, 8'h03);
    chk(tx == 1'b1, "R6 break released", int'(tx), 1);

    // R9 overflow: 20 writes, 17 frames expected.
    cfg(8'h00, 16'd4);
    for (int i = 0; i < 20; i++) wr(4'h0, 8'(i));
    for (int i = 0; i < 17; i++) rx_frame(8'h00, 4, 8'(i), "R9 kept byte", st);
    lows = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx == 1'b0) lows++;
    end
    chk(lows == 0 && tx_empty == 1'b1, "R9 extra dropped", lows, 0);

    // R7 high divisor byte, R10 empty timing.
    cfg(8'h00, 16'h0100);
    wr(4'h0, 8'h15);
    rx_frame(8'h00, 256, 8'h15, "R7 high byte timing", st);
    wait_cyc(st + 112 * 256 - 1);
    chk(tx_empty == 1'b0, "R10 busy in stop", int'(tx_empty), 0);
    wait_cyc(st + 112 * 256 + 1);
    chk(tx_empty == 1'b1, "R10 empty after stop", int'(tx_empty), 1);

    // Random formats and divisors.
    for (int k = 0; k < 24; k++) begin
      l  = {2'b00, 6'($urandom)};
      dv = 1 + int'($urandom % 3);
      cfg(l, 16'(dv));
      send3(l, dv, 8'($urandom), 8'($urandom), 8'($urandom), "R11 random spacing");
    end

    wait_idle();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule